// File: doc/BRIEF.md
# Calendar Clock Register Window

This block is the register front end of a real-time clock and calendar. A 16-bit configuration word holds the run control, a write-unlock bit, two hardware status flags, an output-enable bit, a 2-bit window pointer and an 8-bit calibration byte. The seven time fields (year, month, day, weekday, hours, minutes, seconds) are not mapped one per address. They are reached through one 16-bit value window. Its upper byte and its lower byte each show one field, and the pointer chooses which pair is shown. The pointer steps down by itself on every access that touches the upper byte. Software loads the pointer with 3 and then makes four back-to-back accesses to walk the whole calendar.

A sub-second counter runs from a tick-enable input at `TICKS_PER_SEC` ticks per second. At each whole second a carry sequencer updates the BCD fields one stage per clock, from seconds up to year. A read-sync status flag marks the period in which a read of the value window may see a half-updated calendar. It covers the last tick period before the second boundary and every cycle the carry is still moving. A half-second flag shows which half of the current second is running.

Top module: `rtc_regwin`

## Requirements
- R1: After reset the configuration word reads 0x0000. Its layout is bit 15 run, bit 14 constant 0, bit 13 write-unlock, bit 12 read-sync (read-only), bit 11 half-second (read-only), bit 10 output enable, bits 9:8 pointer, bits 7:0 calibration. `reg_sel`=0 addresses the configuration word and `reg_sel`=1 addresses the value window. `bus_be[1]` enables bits 15:8 and `bus_be[0]` enables bits 7:0.
- R2: A configuration write changes the run bit only when the write-unlock bit was already 1 before that write. The other writable bits always take the written value.
- R3: Writes to the value window change no time field while write-unlock is 0.
- R4: Every read or write of the value window with `bus_be[1]`=1 decrements the pointer by one, whether or not the window is unlocked. The pointer holds at 0. An access with only `bus_be[0]` leaves the pointer unchanged.
- R5: The pointer selects the fields shown as {upper, lower}: 3 selects {reserved, year}, 2 {month, day}, 1 {weekday, hours}, 0 {minutes, seconds}.
- R6: The reserved upper field (pointer 3) always reads 0x00, and writes to it are dropped.
- R7: The half-second flag is 0 while the sub-second count is below `TICKS_PER_SEC`/2 and 1 from there to the end of the second.
- R8: A write of the seconds field (lower byte, pointer 0, unlocked) clears the half-second flag and restarts the sub-second count, so the next second lasts a full `TICKS_PER_SEC` ticks.
- R9: The read-sync flag is 1 while running in the last tick period of a second, and in every cycle the carry sequencer is busy. Otherwise it is 0.
- R10: All fields are BCD. Seconds and minutes wrap 59 to 00, hours 23 to 00, and weekday 6 to 0. Each wrap carries into the next field.
- R11: Day wraps to 01 after the month's last day: 31, 30 for months 04/06/09/11, and 28 for month 02, or 29 when year mod 4 is 0. Month wraps 12 to 01, and year wraps 99 to 00.
- R12: With the run bit at 0, ticks advance neither the sub-second count nor the calendar. The registers stay readable and, when unlocked, writable.
- R13: `bus_rdata` is registered. It shows the addressed word one cycle after a read strobe and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Sub-second tick enable, one pulse per tick period |
| reg_sel | input | 1 | 0 = configuration word, 1 = value window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_be | input | 2 | Byte enables (bit 1 upper, bit 0 lower) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| rtc_on | output | 1 | Run bit |
| rtc_oe | output | 1 | Output-enable bit |
| rtc_cal | output | 8 | Calibration byte |

## Verification
The in-RTL assertions check the following on every cycle: the run bit stays put under a locked write, each pointer step and its floor at 0, the time fields stay frozen under locked writes, a seconds write restarts the sub-second count, and each BCD wrap fires in its own carry stage. The bench sweeps a run of eighty seconds across a full midnight and year rollover. It also sweeps every month's last day over four consecutive years, computing the expected calendar arithmetically. The following only show in bench scenarios: the half-second and read-sync values seen through configuration reads at tick-exact points, and the field mapping seen through a full pointer walk.

// File: rtl/rtc_win_pkg.sv
package rtc_win_pkg;
  localparam int FLD_N = 7;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HR   = 2;
  localparam int F_WDAY = 3;
  localparam int F_DAY  = 4;
  localparam int F_MON  = 5;
  localparam int F_YR   = 6;

  localparam int CB_RUN    = 15;
  localparam int CB_WREN   = 13;
  localparam int CB_SYNC   = 12;
  localparam int CB_HALF   = 11;
  localparam int CB_OE     = 10;
  localparam int CB_PTR_HI = 9;
  localparam int CB_PTR_LO = 8;

  typedef logic [7:0] bcd_t;
  typedef logic [FLD_N-1:0][7:0] fld_vec_t;
  typedef enum logic [2:0] {RS_IDLE, RS_SEC, RS_MIN, RS_HR, RS_DAY, RS_MON, RS_YR} rip_st_t;

  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic bcd_t month_last(bcd_t mon, bcd_t yr);
    logic [7:0] ybin;
    logic       leap;
    ybin = ({4'd0, yr[7:4]} * 8'd10) + {4'd0, yr[3:0]};
    leap = (ybin[1:0] == 2'b00);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t fld_rst(int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int TICKS_PER_SEC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic clr,
  output logic half,
  output logic last,
  output logic roll
);
  localparam int CW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] C_HALF = CW'(TICKS_PER_SEC / 2);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == C_LAST);
  assign roll = last && tick;
  assign half = (cnt >= C_HALF);

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (run && tick) cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
  end

  // R8: a seconds write restarts the sub-second count
  a_r8_clr_restart: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0) && !half);
  // R12: stopped clock holds the sub-second count
  a_r12_hold_cnt: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(cnt));
  // R7: crossing the midpoint raises the half flag
  a_r7_half_rise: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !clr && (cnt == C_HALF - 1'b1)) |=> half);
endmodule

// File: rtl/rtc_cfg_reg.sv
module rtc_cfg_reg
  import rtc_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  input  logic        ptr_dec,
  output logic        run,
  output logic        wren,
  output logic        oe,
  output logic [1:0]  ptr,
  output logic [7:0]  cal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      wren <= 1'b0;
      oe   <= 1'b0;
      ptr  <= 2'b00;
      cal  <= 8'h00;
    end else begin
      if (wr && be[1]) begin
        if (wren) run <= wdata[CB_RUN];
        wren <= wdata[CB_WREN];
        oe   <= wdata[CB_OE];
        ptr  <= wdata[CB_PTR_HI:CB_PTR_LO];
      end else if (ptr_dec && (ptr != 2'b00)) begin
        ptr <= ptr - 2'b01;
      end
      if (wr && be[0]) cal <= wdata[7:0];
    end
  end

  // R2: locked write leaves the run bit alone
  a_r2_run_locked: assert property (@(posedge clk) disable iff (rst)
    (wr && be[1] && !wren) |=> $stable(run));
  // R4: each upper-byte window access steps the pointer down
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (ptr_dec && !wr && (ptr != 2'b00)) |=> (ptr == $past(ptr) - 2'b01));
  // R4: pointer floor at zero
  a_r4_ptr_floor: assert property (@(posedge clk) disable iff (rst)
    (ptr_dec && !wr && (ptr == 2'b00)) |=> (ptr == 2'b00));
endmodule

// File: rtl/rtc_cal_ripple.sv
module rtc_cal_ripple
  import rtc_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             roll,
  input  logic [FLD_N-1:0] wr_en,
  input  fld_vec_t         wr_val,
  output fld_vec_t         fld,
  output logic             busy
);
  rip_st_t  st, st_nx;
  fld_vec_t fld_cnt;
  bcd_t     dlast;

  assign busy  = (st != RS_IDLE);
  assign dlast = month_last(fld[F_MON], fld[F_YR]);

  always_comb begin
    fld_cnt = fld;
    st_nx   = st;
    case (st)
      RS_IDLE: if (roll) st_nx = RS_SEC;
      RS_SEC: begin
        if (fld[F_SEC] >= 8'h59) begin fld_cnt[F_SEC] = 8'h00; st_nx = RS_MIN; end
        else begin fld_cnt[F_SEC] = bcd_inc(fld[F_SEC]); st_nx = RS_IDLE; end
      end
      RS_MIN: begin
        if (fld[F_MIN] >= 8'h59) begin fld_cnt[F_MIN] = 8'h00; st_nx = RS_HR; end
        else begin fld_cnt[F_MIN] = bcd_inc(fld[F_MIN]); st_nx = RS_IDLE; end
      end
      RS_HR: begin
        if (fld[F_HR] >= 8'h23) begin fld_cnt[F_HR] = 8'h00; st_nx = RS_DAY; end
        else begin fld_cnt[F_HR] = bcd_inc(fld[F_HR]); st_nx = RS_IDLE; end
      end
      RS_DAY: begin
        fld_cnt[F_WDAY] = (fld[F_WDAY] >= 8'h06) ? 8'h00 : bcd_inc(fld[F_WDAY]);
        if (fld[F_DAY] >= dlast) begin fld_cnt[F_DAY] = 8'h01; st_nx = RS_MON; end
        else begin fld_cnt[F_DAY] = bcd_inc(fld[F_DAY]); st_nx = RS_IDLE; end
      end
      RS_MON: begin
        if (fld[F_MON] >= 8'h12) begin fld_cnt[F_MON] = 8'h01; st_nx = RS_YR; end
        else begin fld_cnt[F_MON] = bcd_inc(fld[F_MON]); st_nx = RS_IDLE; end
      end
      RS_YR: begin
        fld_cnt[F_YR] = (fld[F_YR] >= 8'h99) ? 8'h00 : bcd_inc(fld[F_YR]);
        st_nx = RS_IDLE;
      end
      default: st_nx = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RS_IDLE;
      for (int i = 0; i < FLD_N; i++) fld[i] <= fld_rst(i);
    end else begin
      st <= st_nx;
      for (int i = 0; i < FLD_N; i++)
        fld[i] <= wr_en[i] ? wr_val[i] : fld_cnt[i];
    end
  end

  // R9: a new second never lands on an unfinished carry
  a_r9_carry_done: assert property (@(posedge clk) disable iff (rst)
    roll |-> !busy);
  // R10: seconds wrap in the seconds stage
  a_r10_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    ((st == RS_SEC) && (fld[F_SEC] == 8'h59) && !wr_en[F_SEC]) |=> (fld[F_SEC] == 8'h00) && (st == RS_MIN));
  // R10: hours wrap at 23
  a_r10_hr_wrap: assert property (@(posedge clk) disable iff (rst)
    ((st == RS_HR) && (fld[F_HR] == 8'h23) && !wr_en[F_HR]) |=> (fld[F_HR] == 8'h00));
  // R11: month wraps to January
  a_r11_mon_wrap: assert property (@(posedge clk) disable iff (rst)
    ((st == RS_MON) && (fld[F_MON] == 8'h12) && !wr_en[F_MON]) |=> (fld[F_MON] == 8'h01));
  // R12: with no second boundary and no write the calendar is frozen
  a_r12_frozen: assert property (@(posedge clk) disable iff (rst)
    (!roll && !busy && (wr_en == '0)) |=> $stable(fld));
endmodule

// File: rtl/rtc_regwin.sv
module rtc_regwin
  import rtc_win_pkg::*;
#(
  parameter int TICKS_PER_SEC = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        reg_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_be,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rtc_on,
  output logic        rtc_oe,
  output logic [7:0]  rtc_cal
);
  logic             run, wren, oe;
  logic [1:0]       ptr;
  logic [7:0]       cal;
  logic             half, last, roll, busy, sync;
  logic             cfg_wr, ptr_dec, val_wr, sec_clr, hi_ok;
  logic [2:0]       hi_idx, lo_idx;
  logic [FLD_N-1:0] wr_en;
  fld_vec_t         wr_val, fld;
  logic [15:0]      cfg_word, val_word;

  assign cfg_wr  = bus_wr && !reg_sel;
  assign ptr_dec = reg_sel && (bus_wr || bus_rd) && bus_be[1];
  assign val_wr  = bus_wr && reg_sel && wren;
  assign sec_clr = val_wr && bus_be[0] && (ptr == 2'b00);
  assign sync    = last || busy;

  always_comb begin
    hi_ok = 1'b1;
    case (ptr)
      2'b11:   begin hi_idx = 3'(F_YR);   lo_idx = 3'(F_YR);  hi_ok = 1'b0; end
      2'b10:   begin hi_idx = 3'(F_MON);  lo_idx = 3'(F_DAY); end
      2'b01:   begin hi_idx = 3'(F_WDAY); lo_idx = 3'(F_HR);  end
      default: begin hi_idx = 3'(F_MIN);  lo_idx = 3'(F_SEC); end
    endcase
  end

  always_comb begin
    wr_en  = '0;
    wr_val = '0;
    if (val_wr && bus_be[1] && hi_ok) begin
      wr_en[hi_idx]  = 1'b1;
      wr_val[hi_idx] = bus_wdata[15:8];
    end
    if (val_wr && bus_be[0]) begin
      wr_en[lo_idx]  = 1'b1;
      wr_val[lo_idx] = bus_wdata[7:0];
    end
  end

  rtc_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .be(bus_be), .wdata(bus_wdata),
    .ptr_dec(ptr_dec), .run(run), .wren(wren), .oe(oe), .ptr(ptr), .cal(cal)
  );

  rtc_subsec #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_sub (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .clr(sec_clr),
    .half(half), .last(last), .roll(roll)
  );

  rtc_cal_ripple u_cal (
    .clk(clk), .rst(rst), .roll(roll), .wr_en(wr_en), .wr_val(wr_val),
    .fld(fld), .busy(busy)
  );

  assign cfg_word = {run, 1'b0, wren, sync, half, oe, ptr, cal};
  assign val_word = {hi_ok ? fld[hi_idx] : 8'h00, fld[lo_idx]};

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= 16'h0000;
    else if (bus_rd) bus_rdata <= reg_sel ? val_word : cfg_word;
  end

  assign rtc_on  = run;
  assign rtc_oe  = oe;
  assign rtc_cal = cal;

  // R1: bit 14 of the configuration word always reads 0
  a_r1_bit14_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !reg_sel) |=> !bus_rdata[14]);
  // R3: locked window writes leave the calendar untouched
  a_r3_locked: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && reg_sel && !wren && !busy && !roll) |=> $stable(fld));
  // R5: pointer 2 shows month over day
  a_r5_mon_day: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && reg_sel && (ptr == 2'b10)) |=> (bus_rdata == {$past(fld[F_MON]), $past(fld[F_DAY])}));
  // R6: reserved upper field reads zero
  a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && reg_sel && (ptr == 2'b11)) |=> (bus_rdata[15:8] == 8'h00));
  // R9: a read during the carry reports the sync flag
  a_r9_sync_busy: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !reg_sel && busy) |=> bus_rdata[CB_SYNC]);
  // R13: read data holds between reads
  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/rtc_regwin_test.sv
`timescale 1ns/1ps
module rtc_regwin_test;
  localparam int TPS = 4;

  logic        clk = 1'b0, rst = 1'b1, tick = 1'b0;
  logic        reg_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0000;
  logic [15:0] bus_rdata;
  logic        rtc_on, rtc_oe;
  logic [7:0]  rtc_cal;
  logic        run_bit = 1'b0;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  rtc_regwin #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst(rst), .tick(tick), .reg_sel(reg_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rtc_on(rtc_on), .rtc_oe(rtc_oe), .rtc_cal(rtc_cal)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int days_in(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); reg_sel = sel; bus_be = be; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_be = 2'b00;
  endtask

  task automatic rd(input logic sel, input logic [1:0] be, output logic [15:0] q);
    @(negedge clk); reg_sel = sel; bus_be = be; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; bus_be = 2'b00; q = bus_rdata;
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic set_time(input logic [7:0] yr, mo, dy, wd, hr, mi, se, input logic go);
    wr(1'b0, 2'b11, 16'h2300);
    wr(1'b0, 2'b11, 16'h2300);
    wr(1'b1, 2'b11, {8'h00, yr});
    wr(1'b1, 2'b11, {mo, dy});
    wr(1'b1, 2'b11, {wd, hr});
    wr(1'b1, 2'b11, {mi, se});
    run_bit = go;
    if (go) wr(1'b0, 2'b11, 16'hA000);
  endtask

  task automatic read_time(output logic [63:0] t);
    logic [15:0] r3, r2, r1, r0;
    wr(1'b0, 2'b11, {run_bit, 7'b0100011, 8'h00});
    rd(1'b1, 2'b11, r3);
    rd(1'b1, 2'b11, r2);
    rd(1'b1, 2'b11, r1);
    rd(1'b1, 2'b11, r0);
    t = {8'h00, r3[7:0], r2, r1, r0};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] q, hold;
    logic [63:0] t, exp;
    int s0, ts, yy, mm, dd, ww;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state and layout
    rd(1'b0, 2'b11, q);
    check("R1 reset word", q, 16'h0000);
    check("R1 reset outputs", {rtc_on, rtc_oe, rtc_cal}, 10'h000);
    wr(1'b0, 2'b11, 16'h7F5A);
    rd(1'b0, 2'b11, q);
    check("R1 layout", q, 16'h275A);

    // R2: run bit gated by the previous unlock state
    wr(1'b0, 2'b11, 16'h0000);
    wr(1'b0, 2'b11, 16'hA4C3);
    rd(1'b0, 2'b11, q);
    check("R2 run ignored while locked", q, 16'h24C3);
    check("R2 outputs", {rtc_on, rtc_oe, rtc_cal}, {1'b0, 1'b1, 8'hC3});
    wr(1'b0, 2'b11, 16'h8000);
    rd(1'b0, 2'b11, q);
    check("R2 run set when unlocked", q, 16'h8000);
    wr(1'b0, 2'b11, 16'h0000);
    rd(1'b0, 2'b11, q);
    check("R2 run kept when locked", q, 16'h8000);

    // R5: field mapping over a pointer walk
    set_time(8'h21, 8'h07, 8'h14, 8'h02, 8'h09, 8'h45, 8'h33, 1'b0);
    wr(1'b0, 2'b11, 16'h2300);
    rd(1'b1, 2'b11, q); check("R5 ptr3 year", q, 16'h0021);
    rd(1'b1, 2'b11, q); check("R5 ptr2 month/day", q, 16'h0714);
    rd(1'b1, 2'b11, q); check("R5 ptr1 weekday/hours", q, 16'h0209);
    rd(1'b1, 2'b11, q); check("R5 ptr0 minutes/seconds", q, 16'h4533);

    // R4: pointer steps and floor
    rd(1'b1, 2'b11, q); check("R4 floor data", q, 16'h4533);
    rd(1'b0, 2'b11, q); check("R4 floor at 0", q, 16'h2000);
    wr(1'b0, 2'b11, 16'h2300);
    rd(1'b1, 2'b01, q);
    rd(1'b0, 2'b11, q); check("R4 lower-only access keeps ptr", q, 16'h2300);
    rd(1'b1, 2'b10, q);
    rd(1'b0, 2'b11, q); check("R4 read steps ptr", q, 16'h2200);

    // R6: reserved field
    wr(1'b0, 2'b11, 16'h2300);
    wr(1'b1, 2'b11, 16'hAB42);
    wr(1'b0, 2'b11, 16'h2300);
    rd(1'b1, 2'b11, q); check("R6 reserved reads 0, year written", q, 16'h0042);

    // R13: read data holds
    hold = q;
    wr(1'b0, 2'b11, 16'h2100);
    repeat (3) @(negedge clk);
    check("R13 rdata holds", bus_rdata, hold);

    // R3 and R4: locked window write
    wr(1'b0, 2'b11, 16'h0300);
    wr(1'b1, 2'b11, 16'h0055);
    rd(1'b0, 2'b11, q); check("R4 locked write steps ptr", q, 16'h0200);
    read_time(t);
    check("R3 locked write ignored", t, {8'h00, 8'h42, 16'h0714, 16'h0209, 16'h4533});

    // R12: stopped clock
    set_time(8'h10, 8'h05, 8'h20, 8'h03, 8'h12, 8'h00, 8'h10, 1'b0);
    give_ticks(8);
    read_time(t);
    check("R12 no count while stopped", t, {8'h00, 8'h10, 16'h0520, 16'h0312, 16'h0010});
    rd(1'b0, 2'b11, q); check("R12 flags quiet while stopped", q, 16'h2000);

    // R7, R8, R9: sub-second flags
    set_time(8'h24, 8'h03, 8'h10, 8'h01, 8'h10, 8'h20, 8'h30, 1'b1);
    rd(1'b0, 2'b11, q); check("R7 first half at start", q, 16'hA000);
    give_ticks(1);
    rd(1'b0, 2'b11, q); check("R7 first half after 1 tick", q, 16'hA000);
    give_ticks(1);
    rd(1'b0, 2'b11, q); check("R7 second half", q, 16'hA800);
    give_ticks(1);
    rd(1'b0, 2'b11, q); check("R9 sync in last tick", q, 16'hB800);
    wr(1'b1, 2'b01, 16'h0005);
    rd(1'b0, 2'b11, q); check("R8 seconds write clears half", q, 16'hA000);
    give_ticks(3);
    read_time(t); check("R8 full second after restart", t[7:0], 8'h05);
    give_ticks(1);
    read_time(t); check("R8 second advances", t[7:0], 8'h06);
    rd(1'b0, 2'b11, q); check("R9 sync clear after carry", q, 16'hA000);

    // R10 and R11: eighty seconds across midnight of the last day of year 99
    set_time(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h58, 8'h50, 1'b1);
    s0 = 23 * 3600 + 58 * 60 + 50;
    for (int k = 1; k <= 80; k++) begin
      give_ticks(TPS);
      read_time(t);
      ts = s0 + k;
      if (ts >= 86400) begin
        ts -= 86400;
        exp = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, to_bcd(ts / 3600), to_bcd((ts / 60) % 60), to_bcd(ts % 60)};
      end else begin
        exp = {8'h00, 8'h99, 8'h12, 8'h31, 8'h06, to_bcd(ts / 3600), to_bcd((ts / 60) % 60), to_bcd(ts % 60)};
      end
      check("R10 R11 second sweep", t, exp);
    end

    // R11: last day of every month over four years
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        dd = days_in(m, y);
        set_time(to_bcd(y), to_bcd(m), to_bcd(dd), 8'h03, 8'h23, 8'h59, 8'h59, 1'b1);
        give_ticks(TPS);
        read_time(t);
        mm = (m == 12) ? 1 : m + 1;
        yy = (m == 12) ? y + 1 : y;
        ww = 4;
        exp = {8'h00, to_bcd(yy), to_bcd(mm), 8'h01, to_bcd(ww), 8'h00, 8'h00, 8'h00};
        check("R11 month end", t, exp);
      end
    end
    set_time(8'h00, 8'h02, 8'h28, 8'h05, 8'h23, 8'h59, 8'h59, 1'b1);
    give_ticks(TPS);
    read_time(t);
    check("R11 leap Feb 29", t, {8'h00, 8'h00, 8'h02, 8'h29, 8'h06, 8'h00, 8'h00, 8'h00});

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule